// File: doc/BRIEF.md
# Key-Protected Watchdog Timer

This block is an independent watchdog for a system controller. Once software starts it, a down-counter driven through a programmable prescaler runs toward zero. When it expires, the block raises a one-cycle reset request and begins a new period. Software keeps the system alive by writing a refresh key before each period ends. Only a system reset can stop the watchdog once it is running.

Software reaches the block through a simple register port with four word-aligned registers: a command register, a prescaler register, a reload register and a status register. Only specific 16-bit key words have any effect on the counter. The prescaler and reload registers accept writes only after an unlock key. Each accepted configuration write raises a busy flag for a fixed number of cycles. This stands in for a slow clock-domain crossing, and the counter uses the new value only when the flag drops.

Top module: `keyed_watchdog`

## Requirements
- R1: After reset the prescaler register reads 0, the reload register reads 0xFFF, the status and command registers read 0, `running_o` is 0 and `wdt_reset_o` is 0.
- R2: Register select is `bus_addr[3:2]`: 0 command, 1 prescaler, 2 reload, 3 status. Writing the word 0x5555 to bits 15:0 of the command register unlocks the configuration registers. While they are locked, writes to the prescaler and reload registers change neither their contents nor the status register.
- R3: Any command write whose bits 15:0 are not 0x5555 re-locks the configuration registers. This includes 0x0000, 0xAAAA and 0xCCCC.
- R4: An accepted prescaler write sets status bit 0, and an accepted reload write sets status bit 1. Each bit can be read from the first cycle after the write and stays set for SYNC_CYCLES (default 3) cycles. The counter starts using the new value in the same cycle that the bit clears.
- R5: Writing 0xCCCC to the command register starts the watchdog. With reload value R and division D, `wdt_reset_o` is high for exactly one cycle, (R+1)*D cycles after the start write, and then again every (R+1)*D cycles.
- R6: Writing 0xAAAA restarts the period, so the next pulse comes (R+1)*D cycles after the refresh write.
- R7: Prescaler codes 0 to 6 divide by 4, 8, 16, 32, 64, 128 and 256. Code 7 divides by 256.
- R8: Once started, the watchdog keeps running and its schedule is unchanged by command writes other than refresh or start. Only `rst_n` stops it.
- R9: Only prescaler bits 2:0 and reload bits 11:0 are stored. The other written bits read back as 0.
- R10: A refresh key written while the watchdog is stopped does not start it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rst_n | input | 1 | Synchronous active-low reset |
| bus_wr | input | 1 | Write strobe for one cycle |
| bus_addr | input | ADDR_W | Byte address; bits 3:2 select the register |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data for `bus_addr`, combinational |
| wdt_reset_o | output | 1 | One-cycle reset request on timeout |
| running_o | output | 1 | Watchdog has been started |

## Verification
Configuration writes are tried both locked and unlocked, and after a non-key command write. This separates the unlock and re-lock paths from the ordinary register storage. Timeouts are measured for three prescaler and reload pairs: code 0 with reload 3, code 2 with reload 1, and code 7 with reload 0. This separates the division table and the clamp of code 7 from an off-by-one in the count. While the watchdog runs, a refresh and then a 0x0000 write are issued in the middle of a period. The first must move the pulse and the second must leave both the pulse and the running state alone. The busy flags are sampled on both sides of their clearing edge.

// File: rtl/wdg_pkg.sv
`timescale 1ns/1ps
// Package: shared key words and register indices for the keyed watchdog.
// Assumes a 16-bit key field in the low bits of the command register.
package wdg_pkg;
    localparam int KEY_W = 16;
    localparam logic [KEY_W-1:0] KEY_UNLOCK  = 16'h5555;
    localparam logic [KEY_W-1:0] KEY_REFRESH = 16'hAAAA;
    localparam logic [KEY_W-1:0] KEY_START   = 16'hCCCC;

    typedef enum logic [1:0] {
        REG_CMD  = 2'd0,
        REG_PSC  = 2'd1,
        REG_RLD  = 2'd2,
        REG_STAT = 2'd3
    } reg_idx_e;
endpackage

// File: rtl/wdg_keys.sv
`timescale 1ns/1ps
// Key decoder: turns command-register writes into start and refresh strobes
// and tracks the unlock state of the configuration registers.
// Assumes cmd_wr is high for one cycle for each bus write.
module wdg_keys
    import wdg_pkg::*;
(
    input  logic             clk,
    input  logic             rst_n,
    input  logic             cmd_wr,
    input  logic [KEY_W-1:0] key,
    output logic             unlocked,
    output logic             start_stb,
    output logic             refresh_stb
);
    // Strobes decoded straight from the write cycle
    always_comb begin
        start_stb   = cmd_wr && (key == KEY_START);
        refresh_stb = cmd_wr && (key == KEY_REFRESH);
    end

    // Unlock flag: set by the unlock key, cleared by any other command write
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            unlocked <= 1'b0;
        end else if (cmd_wr) begin
            unlocked <= (key == KEY_UNLOCK);
        end
    end
endmodule

// File: rtl/wdg_cfg_slot.sv
`timescale 1ns/1ps
// Configuration slot: holds the bus-visible value, and a second copy that the
// counter uses. The second copy takes the new value after SYNC_CYCLES cycles.
// Busy is high while the transfer is pending. Assumes SYNC_CYCLES >= 1.
module wdg_cfg_slot #(
    parameter int              W           = 12,
    parameter logic [W-1:0]    RST_VAL     = '0,
    parameter int              SYNC_CYCLES = 3
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         wr_en,
    input  logic [W-1:0] wdata,
    output logic [W-1:0] bus_q,
    output logic [W-1:0] active_q,
    output logic         busy
);
    localparam int BCNT_W = $clog2(SYNC_CYCLES + 1);

    logic [BCNT_W-1:0] bcnt;

    // Write capture, busy countdown and copy into the counter-side value
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            bus_q    <= RST_VAL;
            active_q <= RST_VAL;
            bcnt     <= '0;
        end else if (wr_en) begin
            bus_q <= wdata;
            bcnt  <= BCNT_W'(SYNC_CYCLES);
        end else if (bcnt != '0) begin
            bcnt <= bcnt - 1'b1;
            if (bcnt == BCNT_W'(1)) begin
                active_q <= bus_q;
            end
        end
    end

    // Busy while a transfer is outstanding
    always_comb busy = (bcnt != '0);
endmodule

// File: rtl/wdg_prescaler.sv
`timescale 1ns/1ps
// Prescaler: produces one tick every (2**BASE_LOG2) << min(code, MAX_CODE)
// cycles while run is high. Clear restarts the division from zero.
module wdg_prescaler #(
    parameter int PSC_W     = 3,
    parameter int BASE_LOG2 = 2,
    parameter int MAX_CODE  = 6
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             run,
    input  logic             clear,
    input  logic [PSC_W-1:0] code,
    output logic             tick
);
    localparam int CNT_W    = BASE_LOG2 + MAX_CODE;
    localparam int CODE_TOP = (1 << PSC_W) - 1;

    logic [CNT_W-1:0] pcnt;
    logic [CNT_W-1:0] limit;
    int unsigned      shift;

    // Code clamp: a clamp is built only if the code can exceed MAX_CODE
    generate
        if (MAX_CODE < CODE_TOP) begin : g_clamp
            always_comb shift = (int'(code) > MAX_CODE) ? MAX_CODE : int'(code);
        end else begin : g_pass
            always_comb shift = int'(code);
        end
    endgenerate

    // Terminal count for the chosen division
    always_comb begin
        limit = CNT_W'((32'd1 << (BASE_LOG2 + shift)) - 32'd1);
        tick  = run && (pcnt == limit);
    end

    // Division counter
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            pcnt <= '0;
        end else if (clear || !run || tick) begin
            pcnt <= '0;
        end else begin
            pcnt <= pcnt + 1'b1;
        end
    end
endmodule

// File: rtl/wdg_downcounter.sv
`timescale 1ns/1ps
// Down-counter: loads the reload value on start or refresh, and counts down
// one step per tick while running. On a tick at zero it emits a one-cycle
// pulse and reloads. Running can only be cleared by reset.
module wdg_downcounter #(
    parameter int RLD_W = 12
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             start,
    input  logic             refresh,
    input  logic             tick,
    input  logic [RLD_W-1:0] reload_val,
    output logic             running,
    output logic             wdt_pulse
);
    logic [RLD_W-1:0] cnt;

    // Running latch, count and timeout pulse
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            running   <= 1'b0;
            cnt       <= '1;
            wdt_pulse <= 1'b0;
        end else begin
            wdt_pulse <= 1'b0;
            if (start) begin
                running <= 1'b1;
            end
            if (start || refresh) begin
                cnt <= reload_val;
            end else if (running && tick) begin
                if (cnt == '0) begin
                    cnt       <= reload_val;
                    wdt_pulse <= 1'b1;
                end else begin
                    cnt <= cnt - 1'b1;
                end
            end
        end
    end
endmodule

// File: rtl/keyed_watchdog.sv
`timescale 1ns/1ps
// Keyed watchdog top: decodes the register port, routes keys and guarded
// configuration writes, and chains prescaler and down-counter.
// Assumes single-cycle writes and word-aligned addresses (bits 3:2 select).
module keyed_watchdog
    import wdg_pkg::*;
#(
    parameter int ADDR_W      = 4,
    parameter int PSC_W       = 3,
    parameter int RLD_W       = 12,
    parameter int SYNC_CYCLES = 3,
    parameter int BASE_LOG2   = 2,
    parameter int MAX_CODE    = 6
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              bus_wr,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic [31:0]       bus_wdata,
    output logic [31:0]       bus_rdata,
    output logic              wdt_reset_o,
    output logic              running_o
);
    localparam logic [RLD_W-1:0] RLD_RST = '1;
    localparam logic [PSC_W-1:0] PSC_RST = '0;

    reg_idx_e         sel;
    logic             cmd_wr, psc_wr, rld_wr;
    logic             unlocked_w, start_w, refresh_w, tick_w;
    logic [PSC_W-1:0] psc_reg_w, psc_act_w;
    logic [RLD_W-1:0] rld_reg_w, rld_act_w;
    logic             psc_busy_w, rld_busy_w;
    logic [1:0]       status_w;
    logic             unused_bits;

    assign unused_bits = ^{bus_addr, bus_wdata};

    // Register select and write qualification
    always_comb begin
        sel    = reg_idx_e'(bus_addr[3:2]);
        cmd_wr = bus_wr && (sel == REG_CMD);
        psc_wr = bus_wr && (sel == REG_PSC) && unlocked_w;
        rld_wr = bus_wr && (sel == REG_RLD) && unlocked_w;
    end

    wdg_keys u_keys (
        .clk         (clk),
        .rst_n       (rst_n),
        .cmd_wr      (cmd_wr),
        .key         (bus_wdata[KEY_W-1:0]),
        .unlocked    (unlocked_w),
        .start_stb   (start_w),
        .refresh_stb (refresh_w)
    );

    wdg_cfg_slot #(.W(PSC_W), .RST_VAL(PSC_RST), .SYNC_CYCLES(SYNC_CYCLES)) u_psc (
        .clk      (clk),
        .rst_n    (rst_n),
        .wr_en    (psc_wr),
        .wdata    (bus_wdata[PSC_W-1:0]),
        .bus_q    (psc_reg_w),
        .active_q (psc_act_w),
        .busy     (psc_busy_w)
    );

    wdg_cfg_slot #(.W(RLD_W), .RST_VAL(RLD_RST), .SYNC_CYCLES(SYNC_CYCLES)) u_rld (
        .clk      (clk),
        .rst_n    (rst_n),
        .wr_en    (rld_wr),
        .wdata    (bus_wdata[RLD_W-1:0]),
        .bus_q    (rld_reg_w),
        .active_q (rld_act_w),
        .busy     (rld_busy_w)
    );

    wdg_prescaler #(.PSC_W(PSC_W), .BASE_LOG2(BASE_LOG2), .MAX_CODE(MAX_CODE)) u_psc_div (
        .clk   (clk),
        .rst_n (rst_n),
        .run   (running_o),
        .clear (start_w || refresh_w),
        .code  (psc_act_w),
        .tick  (tick_w)
    );

    wdg_downcounter #(.RLD_W(RLD_W)) u_cnt (
        .clk        (clk),
        .rst_n      (rst_n),
        .start      (start_w),
        .refresh    (refresh_w),
        .tick       (tick_w),
        .reload_val (rld_act_w),
        .running    (running_o),
        .wdt_pulse  (wdt_reset_o)
    );

    // Read-back multiplexer; the command register reads as zero
    always_comb begin
        status_w = {rld_busy_w, psc_busy_w};
        unique case (sel)
            REG_PSC:  bus_rdata = 32'(psc_reg_w);
            REG_RLD:  bus_rdata = 32'(rld_reg_w);
            REG_STAT: bus_rdata = 32'(status_w);
            default:  bus_rdata = 32'd0;
        endcase
    end
endmodule

// File: rtl/keyed_watchdog_sva.sv
`timescale 1ns/1ps
// Checker for keyed_watchdog: protocol properties on ports and internal state.
module keyed_watchdog_sva
    import wdg_pkg::*;
#(
    parameter int ADDR_W = 4,
    parameter int PSC_W  = 3
) (
    input logic              clk,
    input logic              rst_n,
    input logic              bus_wr,
    input logic [ADDR_W-1:0] bus_addr,
    input logic [31:0]       bus_wdata,
    input logic              wdt_reset_o,
    input logic              running_o,
    input logic              unlocked,
    input logic [PSC_W-1:0]  psc_reg,
    input logic [1:0]        status
);
    logic cmd_w, psc_w;
    logic unused_bits;
    assign unused_bits = ^{bus_addr, bus_wdata};
    assign cmd_w = bus_wr && (bus_addr[3:2] == 2'd0);
    assign psc_w = bus_wr && (bus_addr[3:2] == 2'd1);

    a_r5_pulse_single: assert property (@(posedge clk) disable iff (!rst_n)
        wdt_reset_o |=> !wdt_reset_o);
    a_r5_pulse_needs_run: assert property (@(posedge clk) disable iff (!rst_n)
        wdt_reset_o |-> running_o);
    a_r8_no_stop: assert property (@(posedge clk) disable iff (!rst_n)
        running_o |=> running_o);
    a_r2_unlock: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd_w && bus_wdata[KEY_W-1:0] == KEY_UNLOCK) |=> unlocked);
    a_r3_relock: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd_w && bus_wdata[KEY_W-1:0] != KEY_UNLOCK) |=> !unlocked);
    a_r2_locked_psc: assert property (@(posedge clk) disable iff (!rst_n)
        (psc_w && !unlocked) |=> $stable(psc_reg));
    a_r4_psc_busy: assert property (@(posedge clk) disable iff (!rst_n)
        (psc_w && unlocked) |=> status[0]);
    a_r10_refresh_no_start: assert property (@(posedge clk) disable iff (!rst_n)
        (!running_o && cmd_w && bus_wdata[KEY_W-1:0] == KEY_REFRESH) |=> !running_o);
endmodule

bind keyed_watchdog keyed_watchdog_sva #(.ADDR_W(ADDR_W), .PSC_W(PSC_W)) u_sva (
    .clk         (clk),
    .rst_n       (rst_n),
    .bus_wr      (bus_wr),
    .bus_addr    (bus_addr),
    .bus_wdata   (bus_wdata),
    .wdt_reset_o (wdt_reset_o),
    .running_o   (running_o),
    .unlocked    (unlocked_w),
    .psc_reg     (psc_reg_w),
    .status      (status_w)
);

// File: tb/keyed_watchdog_tb_top.sv
`timescale 1ns/1ps
// Scoreboard bench: the driver queues expected items, and the monitor compares
// them just after the next rising edge.
module keyed_watchdog_tb_top;
    localparam logic [3:0] A_CMD = 4'h0, A_PSC = 4'h4, A_RLD = 4'h8, A_STAT = 4'hC;
    localparam int K_RDATA = 0, K_WDT = 1, K_RUN = 2;

    typedef struct {
        int          kind;
        logic [31:0] exp;
        string       tag;
    } item_t;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        bus_wr = 1'b0;
    logic [3:0]  bus_addr = '0;
    logic [31:0] bus_wdata = '0;
    logic [31:0] bus_rdata;
    logic        wdt_reset_o, running_o;

    item_t q[$];
    int    checks = 0;
    int    failures = 0;
    int    stage = 0;
    bit    done = 1'b0;

    keyed_watchdog dut_i (
        .clk         (clk),
        .rst_n       (rst_n),
        .bus_wr      (bus_wr),
        .bus_addr    (bus_addr),
        .bus_wdata   (bus_wdata),
        .bus_rdata   (bus_rdata),
        .wdt_reset_o (wdt_reset_o),
        .running_o   (running_o)
    );

    always #2.5 clk = ~clk;

    task automatic finish_run();
        if (!done) begin
            done = 1'b1;
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    endtask

    // Monitor: pop every queued item and compare it just after the rising edge
    initial forever begin
        @(posedge clk);
        #2;
        while (q.size() > 0) begin
            item_t it;
            logic [31:0] obs;
            it = q.pop_front();
            case (it.kind)
                K_RDATA: obs = bus_rdata;
                K_WDT:   obs = {31'd0, wdt_reset_o};
                default: obs = {31'd0, running_o};
            endcase
            checks++;
            if (obs !== it.exp) begin
                failures++;
                $display("FAIL %s: actual=0x%08h expected=0x%08h", it.tag, obs, it.exp);
            end
        end
    end

    task automatic push(int kind, logic [31:0] exp, string tag);
        item_t it;
        it.kind = kind; it.exp = exp; it.tag = tag;
        q.push_back(it);
    endtask

    task automatic step();
        @(negedge clk);
        stage++;
    endtask

    // Queue an item that is compared after rising edge k of the last write
    task automatic at(int k, int kind, logic [31:0] exp, string tag);
        while (stage < k - 1) step();
        push(kind, exp, tag);
    endtask

    task automatic rd(logic [3:0] a, logic [31:0] exp, string tag);
        bus_addr = a;
        push(K_RDATA, exp, tag);
        step();
    endtask

    task automatic wr(logic [3:0] a, logic [31:0] d);
        bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
        @(negedge clk);
        bus_wr = 1'b0;
        stage = 0;
    endtask

    task automatic do_reset();
        rst_n = 1'b0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        stage = 0;
    endtask

    task automatic cfg_and_start(logic [31:0] p, logic [31:0] r);
        wr(A_CMD, 32'h5555);
        wr(A_PSC, p);
        wr(A_RLD, r);
        repeat (5) step();
        wr(A_CMD, 32'hCCCC);
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        failures++;
        $display("FAIL watchdog: actual=hung expected=done");
        finish_run();
    end

    initial begin
        @(negedge clk);
        do_reset();
        // R1 reset state
        rd(A_PSC, 32'h0, "R1 psc reset");
        rd(A_RLD, 32'hFFF, "R1 rld reset");
        rd(A_STAT, 32'h0, "R1 stat reset");
        rd(A_CMD, 32'h0, "R1 cmd reads zero");
        push(K_RUN, 0, "R1 running reset");
        push(K_WDT, 0, "R1 wdt reset");
        step();
        // R10 refresh while stopped
        wr(A_CMD, 32'hAAAA);
        at(1, K_RUN, 0, "R10 refresh no start");
        at(20, K_RUN, 0, "R10 still stopped");
        push(K_WDT, 0, "R10 no pulse");
        step();
        // R2 locked writes ignored
        wr(A_PSC, 32'h5);
        rd(A_PSC, 32'h0, "R2 locked psc");
        wr(A_RLD, 32'h10);
        rd(A_RLD, 32'hFFF, "R2 locked rld");
        rd(A_STAT, 32'h0, "R2 locked no busy");
        // R4 busy timing, R9 field masking
        wr(A_CMD, 32'h5555);
        wr(A_RLD, 32'hFFFF_F003);
        rd(A_STAT, 32'h2, "R4 rld busy edge1");
        rd(A_STAT, 32'h2, "R4 rld busy edge2");
        rd(A_STAT, 32'h0, "R4 rld clear edge3");
        rd(A_RLD, 32'h003, "R9 rld masked");
        wr(A_PSC, 32'hFFFF_FFF9);
        rd(A_STAT, 32'h1, "R4 psc busy");
        rd(A_PSC, 32'h1, "R9 psc masked");
        repeat (4) step();
        // R3 re-lock by non-key write
        wr(A_CMD, 32'h1234);
        wr(A_PSC, 32'h4);
        rd(A_PSC, 32'h1, "R3 relocked psc");
        rd(A_STAT, 32'h0, "R3 relocked no busy");
        // R5 code 0 reload 3: period 16
        cfg_and_start(32'h0, 32'h3);
        at(1, K_RUN, 1, "R5 running");
        at(15, K_WDT, 0, "R5 before timeout");
        at(16, K_WDT, 1, "R5 timeout");
        at(17, K_WDT, 0, "R5 one cycle");
        at(31, K_WDT, 0, "R5 before second");
        at(32, K_WDT, 1, "R5 periodic");
        at(36, K_WDT, 0, "R5 idle");
        // R6 refresh moves the pulse
        wr(A_CMD, 32'hAAAA);
        at(12, K_WDT, 0, "R6 old schedule gone");
        at(16, K_WDT, 1, "R6 after refresh");
        at(20, K_WDT, 0, "R8 idle");
        // R8 a 0x0000 write neither stops nor reschedules
        wr(A_CMD, 32'h0000);
        at(1, K_RUN, 1, "R8 still running");
        at(11, K_WDT, 0, "R8 before pulse");
        at(12, K_WDT, 1, "R8 schedule kept");
        step();
        do_reset();
        push(K_RUN, 0, "R8 reset stops");
        step();
        // R7 code 7 acts as 256, reload 0
        cfg_and_start(32'h7, 32'h0);
        at(255, K_WDT, 0, "R7 code7 early");
        at(256, K_WDT, 1, "R7 code7 div256");
        at(512, K_WDT, 1, "R7 code7 periodic");
        step();
        do_reset();
        // R7 code 2 reload 1: period 32
        cfg_and_start(32'h2, 32'h1);
        at(31, K_WDT, 0, "R7 code2 early");
        at(32, K_WDT, 1, "R7 code2 div16");
        repeat (3) step();
        if (q.size() != 0) begin
            failures++;
            $display("FAIL scoreboard: actual=%0d expected=0 pending", q.size());
        end
        finish_run();
    end
endmodule